// File: doc/BRIEF.md
# Flash Block Key Deriver

This block turns the secret key held in fuse storage into the key that a flash encryption engine feeds to its AES core for one 32-byte flash block. It puts the stored key into the byte order the core expects. When the fuses use the reduced coding scheme, it widens a 192-bit stored key to 256 bits. It then folds the block index into the key. The block index is bits 23..5 of the flash byte address. It is folded in only over the key segments that a 4-bit tweak configuration enables. Every 32-byte block therefore gets its own key, and the two 16-byte AES blocks inside it share that key.

Each accepted request also yields two results. The first is the AES direction: a flash write (encrypt) runs the core in decryption, and a flash read (decrypt) runs it in encryption. The second is an alignment error flag for encrypted writes whose start address or length is not a multiple of 16 bytes.

All results are registered and come with a one-cycle `keyValid` strobe. The key register is reloaded only when the block index, the configuration or the coding scheme differs from the last loaded key.

Top module: `flash_key_deriver`

## Requirements
- R1: While reset is low, and right after it is released, `keyOut`, `keyValid`, `aesDecrypt` and `alignErr` are all zero.
- R2: `keyValid` is high exactly in the cycle after a cycle in which `reqValid` was high, and low in every other cycle.
- R3: With `codingSel`=0 and `tweakCfg`=0, byte i of `keyOut` (bits 8i+7..8i) equals byte 31-i of `fuseKey`.
- R4: With `codingSel`=1 and `tweakCfg`=0, byte i of `keyOut` for i in 0..23 equals byte 23-i of `fuseKey`, `keyOut[255:192]` equals `keyOut[127:64]`, and `fuseKey[255:192]` has no effect.
- R5: Key bit k is inverted when, and only when, its segment is enabled and address bit 5+(k mod 19) is 1. `tweakCfg[0]` enables key bits 0..66, `[1]` enables 67..131, `[2]` enables 132..194 and `[3]` enables 195..255.
- R6: Address bits 4..0 have no effect on the key: all addresses in one 32-byte block, including both 16-byte halves, give the same key.
- R7: With `tweakCfg`=0, every block address gives the same key.
- R8: The first request after reset always loads the key. A later request loads it only if address bits 23..5, `tweakCfg` or `codingSel` differ from those of the last load. Otherwise `keyOut` keeps its old value, even if `fuseKey` has changed.
- R9: After a request, `aesDecrypt` is 1 if `reqWrite` was 1 (encrypt request) and 0 if it was 0 (decrypt request).
- R10: After a write request, `alignErr` is 1 if `reqAddr[3:0]` or `reqLen[3:0]` is nonzero, and 0 otherwise. After a read request it is always 0.
- R11: In cycles without a request, `keyOut`, `aesDecrypt` and `alignErr` keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fuseKey | input | 256 | Key as held in fuse storage |
| codingSel | input | 1 | 0: full 256-bit key stored; 1: 192-bit key in bits 191..0 |
| tweakCfg | input | 4 | Enable bit for each of the four key segments |
| reqValid | input | 1 | A request is presented this cycle |
| reqAddr | input | 24 | Flash byte address of the request |
| reqWrite | input | 1 | 1: encrypted write (encrypt), 0: read (decrypt) |
| reqLen | input | 12 | Write length in bytes |
| keyOut | output | 256 | Derived per-block AES key |
| keyValid | output | 1 | One-cycle strobe: the results of a request are ready |
| aesDecrypt | output | 1 | AES direction to use: 1 = decrypt |
| alignErr | output | 1 | Write request breaks the 16-byte alignment rule |

## Verification
Two functions can act in the same cycle. The hold rule keeps the key register frozen, while the direction and alignment flags are reloaded by every request. The bench provokes this by moving a misaligned write into the same 32-byte block as the previous request and changing the fuse key at the same time. It then expects the old key together with fresh `aesDecrypt` and `alignErr` values. A companion request one block further on must pick up the new fuse key, which shows that the old key was frozen and not simply lost.

// File: rtl/fkd_pkg.sv
package fkd_pkg;
  // strobes from the control section to the datapath
  typedef struct packed {
    logic accept;   // a request is taken this cycle
    logic loadKey;  // the derived key must be captured
  } ctrlStrobe_t;
endpackage

// File: rtl/fkd_ctrl.sv
module fkd_ctrl
  import fkd_pkg::*;
#(
  parameter int OFF_W = 19,
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [OFF_W-1:0] blkIdx,
  input  logic [CFG_W-1:0] tweakCfg,
  input  logic             codingSel,
  output ctrlStrobe_t      strobe
);
  logic [OFF_W-1:0] lastBlk;
  logic [CFG_W-1:0] lastCfg;
  logic             lastCode;
  logic             haveKey;
  logic             changed;

  always_comb begin
    changed = !haveKey || (blkIdx != lastBlk) || (tweakCfg != lastCfg) ||
              (codingSel != lastCode);
    strobe.accept  = reqValid;
    strobe.loadKey = reqValid && changed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastBlk  <= '0;
      lastCfg  <= '0;
      lastCode <= 1'b0;
      haveKey  <= 1'b0;
    end else if (strobe.loadKey) begin
      lastBlk  <= blkIdx;
      lastCfg  <= tweakCfg;
      lastCode <= codingSel;
      haveKey  <= 1'b1;
    end
  end
endmodule

// File: rtl/fkd_datapath.sv
module fkd_datapath
  import fkd_pkg::*;
#(
  parameter int KEY_W      = 256,
  parameter int OFF_W      = 19,
  parameter int CFG_W      = 4,
  parameter int LEN_W      = 12,
  parameter int ALIGN_LSB  = 4,
  parameter int RED_W      = 192,
  parameter int EXT_LO     = 64,
  parameter int SEG1_LO    = 67,
  parameter int SEG2_LO    = 132,
  parameter int SEG3_LO    = 195,
  parameter int TAP_STRIDE = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [KEY_W-1:0]     fuseKey,
  input  logic                 codingSel,
  input  logic [CFG_W-1:0]     tweakCfg,
  input  logic [OFF_W-1:0]     blkIdx,
  input  logic [ALIGN_LSB-1:0] addrLow,
  input  logic                 reqWrite,
  input  logic [LEN_W-1:0]     reqLen,
  output logic [KEY_W-1:0]     keyOut,
  output logic                 keyValid,
  output logic                 aesDecrypt,
  output logic                 alignErr
);
  localparam int NBYTES  = KEY_W / 8;
  localparam int RBYTES  = RED_W / 8;
  localparam int EXT_W   = KEY_W - RED_W;

  logic [KEY_W-1:0] fullRev;
  logic [RED_W-1:0] redRev;
  logic [KEY_W-1:0] baseKey;
  logic [KEY_W-1:0] derived;
  logic             misaligned;

  always_comb begin
    for (int i = 0; i < NBYTES; i++)
      fullRev[8*i +: 8] = fuseKey[8*(NBYTES-1-i) +: 8];
    for (int i = 0; i < RBYTES; i++)
      redRev[8*i +: 8] = fuseKey[8*(RBYTES-1-i) +: 8];
    baseKey = codingSel ? {redRev[EXT_LO +: EXT_W], redRev} : fullRev;
  end

  // each key bit takes one offset bit, gated by its segment enable
  for (genvar k = 0; k < KEY_W; k++) begin : g_tweak
    localparam int SEG = (k < SEG1_LO) ? 0 : (k < SEG2_LO) ? 1 : (k < SEG3_LO) ? 2 : 3;
    localparam int TAP = (k * TAP_STRIDE) % OFF_W;
    assign derived[k] = baseKey[k] ^ (tweakCfg[SEG] & blkIdx[TAP]);
  end

  assign misaligned = (addrLow != '0) || (reqLen[ALIGN_LSB-1:0] != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyOut     <= '0;
      keyValid   <= 1'b0;
      aesDecrypt <= 1'b0;
      alignErr   <= 1'b0;
    end else begin
      keyValid <= strobe.accept;
      if (strobe.loadKey) keyOut <= derived;
      if (strobe.accept) begin
        aesDecrypt <= reqWrite;
        alignErr   <= reqWrite && misaligned;
      end
    end
  end
endmodule

// File: rtl/flash_key_deriver.sv
module flash_key_deriver
  import fkd_pkg::*;
#(
  parameter int KEY_W     = 256,
  parameter int ADDR_W    = 24,
  parameter int BLK_LSB   = 5,
  parameter int ALIGN_LSB = 4,
  parameter int CFG_W     = 4,
  parameter int LEN_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [KEY_W-1:0]  fuseKey,
  input  logic              codingSel,
  input  logic [CFG_W-1:0]  tweakCfg,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [LEN_W-1:0]  reqLen,
  output logic [KEY_W-1:0]  keyOut,
  output logic              keyValid,
  output logic              aesDecrypt,
  output logic              alignErr
);
  localparam int OFF_W = ADDR_W - BLK_LSB;

  ctrlStrobe_t      strobe;
  logic [OFF_W-1:0] blkIdx;
  logic             unusedAddrBits;

  assign blkIdx = reqAddr[ADDR_W-1:BLK_LSB];
  assign unusedAddrBits = ^reqAddr[BLK_LSB-1:ALIGN_LSB];

  fkd_ctrl #(.OFF_W(OFF_W), .CFG_W(CFG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .blkIdx(blkIdx),
    .tweakCfg(tweakCfg), .codingSel(codingSel), .strobe(strobe)
  );

  fkd_datapath #(
    .KEY_W(KEY_W), .OFF_W(OFF_W), .CFG_W(CFG_W), .LEN_W(LEN_W), .ALIGN_LSB(ALIGN_LSB)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fuseKey(fuseKey), .codingSel(codingSel),
    .tweakCfg(tweakCfg), .blkIdx(blkIdx), .addrLow(reqAddr[ALIGN_LSB-1:0]),
    .reqWrite(reqWrite), .reqLen(reqLen), .keyOut(keyOut), .keyValid(keyValid),
    .aesDecrypt(aesDecrypt), .alignErr(alignErr)
  );
endmodule

// File: rtl/fkd_checker.sv
module fkd_checker #(
  parameter int KEY_W   = 256,
  parameter int ADDR_W  = 24,
  parameter int BLK_LSB = 5,
  parameter int CFG_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [CFG_W-1:0]  tweakCfg,
  input logic              codingSel,
  input logic [KEY_W-1:0]  keyOut,
  input logic              keyValid,
  input logic              aesDecrypt,
  input logic              alignErr
);
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> keyValid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !keyValid); // R2
  AST_DIR_INVERTED: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (aesDecrypt == $past(reqWrite))); // R9
  AST_READ_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> !alignErr); // R10
  AST_KEY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && keyValid && (reqAddr[ADDR_W-1:BLK_LSB] == $past(reqAddr[ADDR_W-1:BLK_LSB])) &&
     (tweakCfg == $past(tweakCfg)) && (codingSel == $past(codingSel))) |=> $stable(keyOut)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(keyOut) && $stable(aesDecrypt) && $stable(alignErr))); // R11
endmodule

bind flash_key_deriver fkd_checker #(
  .KEY_W(KEY_W), .ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .CFG_W(CFG_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
  .tweakCfg(tweakCfg), .codingSel(codingSel), .keyOut(keyOut), .keyValid(keyValid),
  .aesDecrypt(aesDecrypt), .alignErr(alignErr)
);

// File: tb/sim_flash_key_deriver.sv
`timescale 1ns/1ps
module sim_flash_key_deriver;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [255:0] fuseKey = '0;
  logic         codingSel = 1'b0;
  logic [3:0]   tweakCfg = '0;
  logic         reqValid = 1'b0;
  logic [23:0]  reqAddr = '0;
  logic         reqWrite = 1'b0;
  logic [11:0]  reqLen = '0;
  logic [255:0] keyOut;
  logic         keyValid, aesDecrypt, alignErr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_key_deriver u0 (
    .clk(clk), .rstN(rstN), .fuseKey(fuseKey), .codingSel(codingSel), .tweakCfg(tweakCfg),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite), .reqLen(reqLen),
    .keyOut(keyOut), .keyValid(keyValid), .aesDecrypt(aesDecrypt), .alignErr(alignErr)
  );

  function automatic logic [255:0] patKey(int seed);
    logic [255:0] v;
    for (int i = 0; i < 32; i++) v[8*i +: 8] = 8'(i * 37 + seed * 11 + 5);
    return v;
  endfunction

  function automatic logic [255:0] expKey(logic [255:0] f, logic code, logic [3:0] cfg,
                                          logic [23:0] a);
    logic [255:0] b;
    int seg;
    if (!code) begin
      for (int i = 0; i < 32; i++) b[8*i +: 8] = f[8*(31-i) +: 8];
    end else begin
      b = '0;
      for (int i = 0; i < 24; i++) b[8*i +: 8] = f[8*(23-i) +: 8];
      b[255:192] = b[127:64];
    end
    for (int k = 0; k < 256; k++) begin
      seg = (k < 67) ? 0 : (k < 132) ? 1 : (k < 195) ? 2 : 3;
      if (cfg[seg] && a[5 + (k % 19)]) b[k] = ~b[k];
    end
    return b;
  endfunction

  task automatic chkKey(string req, logic [255:0] act, logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s key act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chkBit(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
    end
  endtask

  // drive one request at a falling edge; return at the next falling edge
  task automatic doReq(logic [23:0] a, logic w, logic [11:0] len);
    reqAddr = a; reqWrite = w; reqLen = len; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic tReset();
    @(negedge clk);
    chkBit("R1", "keyOut zero", keyOut == '0, 1'b1);
    chkBit("R1", "keyValid", keyValid, 1'b0);
    chkBit("R1", "aesDecrypt", aesDecrypt, 1'b0);
    chkBit("R1", "alignErr", alignErr, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chkBit("R1", "keyOut zero after release", keyOut == '0, 1'b1);
    chkBit("R2", "keyValid idle", keyValid, 1'b0);
  endtask

  task automatic tFullScheme();
    fuseKey = patKey(1); codingSel = 1'b0; tweakCfg = 4'h0;
    doReq(24'h000040, 1'b0, 12'd0);
    chkBit("R2", "keyValid after req", keyValid, 1'b1);
    chkKey("R3", keyOut, expKey(fuseKey, 1'b0, 4'h0, 24'h000040));
    chkBit("R3", "byte0 from byte31", keyOut[7:0] == fuseKey[255:248], 1'b1);
    @(negedge clk);
    chkBit("R2", "keyValid drops", keyValid, 1'b0);
  endtask

  task automatic tReducedScheme();
    logic [255:0] first;
    fuseKey = patKey(2); codingSel = 1'b1; tweakCfg = 4'h0;
    doReq(24'h000080, 1'b0, 12'd0);
    chkKey("R4", keyOut, expKey(fuseKey, 1'b1, 4'h0, 24'h000080));
    chkBit("R4", "upper copy", keyOut[255:192] == keyOut[127:64], 1'b1);
    first = keyOut;
    fuseKey[255:192] = ~fuseKey[255:192];
    doReq(24'h0000A0, 1'b0, 12'd0);
    chkKey("R4", keyOut, first);
  endtask

  task automatic tTweak();
    logic [23:0] addrs [4] = '{24'h7FFFE0, 24'h123460, 24'hA5A5A0, 24'hFFFFE0};
    logic [3:0]  cfgs  [4] = '{4'h1, 4'h6, 4'hF, 4'h8};
    fuseKey = patKey(3); codingSel = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tweakCfg = cfgs[i];
      doReq(addrs[i], 1'b0, 12'd0);
      chkKey("R5", keyOut, expKey(fuseKey, 1'b0, cfgs[i], addrs[i]));
    end
    codingSel = 1'b1; tweakCfg = 4'hB;
    doReq(24'h5A5A40, 1'b0, 12'd0);
    chkKey("R5", keyOut, expKey(fuseKey, 1'b1, 4'hB, 24'h5A5A40));
  endtask

  task automatic tLowBits();
    logic [255:0] ref0;
    fuseKey = patKey(4); codingSel = 1'b0; tweakCfg = 4'hF;
    doReq(24'h333300, 1'b0, 12'd0);
    ref0 = keyOut;
    chkKey("R6", ref0, expKey(fuseKey, 1'b0, 4'hF, 24'h333300));
    doReq(24'h333310, 1'b0, 12'd0);
    chkKey("R6", keyOut, ref0);
    doReq(24'h33331F, 1'b0, 12'd0);
    chkKey("R6", keyOut, ref0);
  endtask

  task automatic tCfgZero();
    logic [255:0] ref0;
    fuseKey = patKey(5); codingSel = 1'b0; tweakCfg = 4'h0;
    doReq(24'h000000, 1'b0, 12'd0);
    ref0 = keyOut;
    doReq(24'hFFFFE0, 1'b0, 12'd0);
    chkKey("R7", keyOut, ref0);
    doReq(24'h555540, 1'b1, 12'd16);
    chkKey("R7", keyOut, ref0);
  endtask

  // key hold and flag update in the same request
  task automatic tHold();
    logic [255:0] k1;
    fuseKey = patKey(6); codingSel = 1'b0; tweakCfg = 4'hF;
    doReq(24'h100000, 1'b0, 12'd0);
    k1 = keyOut;
    chkKey("R8", k1, expKey(fuseKey, 1'b0, 4'hF, 24'h100000));
    fuseKey = patKey(7);
    doReq(24'h100018, 1'b1, 12'd16);
    chkKey("R8", keyOut, k1);
    chkBit("R9", "aesDecrypt write", aesDecrypt, 1'b1);
    chkBit("R10", "alignErr misaligned addr", alignErr, 1'b1);
    tweakCfg = 4'h7;
    doReq(24'h100000, 1'b0, 12'd0);
    chkKey("R8", keyOut, expKey(fuseKey, 1'b0, 4'h7, 24'h100000));
    tweakCfg = 4'hF;
    doReq(24'h100020, 1'b0, 12'd0);
    chkKey("R8", keyOut, expKey(fuseKey, 1'b0, 4'hF, 24'h100020));
  endtask

  task automatic tDirAlign();
    doReq(24'h000010, 1'b1, 12'd32);
    chkBit("R9", "aesDecrypt write", aesDecrypt, 1'b1);
    chkBit("R10", "aligned write", alignErr, 1'b0);
    doReq(24'h000020, 1'b1, 12'd24);
    chkBit("R10", "bad length", alignErr, 1'b1);
    doReq(24'h000007, 1'b0, 12'd5);
    chkBit("R9", "aesDecrypt read", aesDecrypt, 1'b0);
    chkBit("R10", "read never flags", alignErr, 1'b0);
  endtask

  task automatic tIdle();
    logic [255:0] k;
    doReq(24'h000044, 1'b1, 12'd16);
    k = keyOut;
    reqAddr = 24'hABCDE0; reqWrite = 1'b0; reqLen = 12'd3;
    fuseKey = patKey(9); tweakCfg = 4'h5; codingSel = 1'b1;
    repeat (3) @(negedge clk);
    chkKey("R11", keyOut, k);
    chkBit("R11", "aesDecrypt held", aesDecrypt, 1'b1);
    chkBit("R11", "alignErr held", alignErr, 1'b1);
    chkBit("R2", "keyValid idle", keyValid, 1'b0);
  endtask

  initial begin
    tReset();
    tFullScheme();
    tReducedScheme();
    tTweak();
    tLowBits();
    tCfgZero();
    tHold();
    tDirAlign();
    tIdle();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule